// File: doc/BRIEF.md
# Selectable-Tap Free-Running Timer

An 8-bit timer peripheral that advances by one on every clock and cannot be paused, gated or preloaded. There is no prescaler: the counter runs at the full input clock rate and returns to zero after 255. One of its bits is routed to an output pin as a square wave. This gives a divided clock whose ratio is a power of two from 2 to 128.

The processor picks the ratio by writing a 3-bit code to the bus address where the timer is mapped (0x080 on a 12-bit address bus). Only the low three bits of the write data are kept. A new code moves the output tap in the cycle after the write, and the running count is left untouched. Reset clears both the count and the code, so the block comes out of reset dividing by two.

Top module: `tmr_tap_timer`

## Requirements
- R1: While rst_n is low, and in the first cycle after it is released, tmr_count reads 0, the select code is 0 and tmr_tick is 0.
- R2: With rst_n high, tmr_count rises by exactly one on every rising clock edge, and goes from 255 back to 0 with no stall.
- R3: A rising edge with bus_wr high and bus_addr equal to 12'h080 loads bus_wdata[2:0] as the select code. The code takes effect from the next cycle.
- R4: A write to any other address, or a cycle with bus_wr low, leaves the select code unchanged.
- R5: For select code k from 0 to 6, tmr_tick equals bit k of tmr_count, which divides the clock by 2^(k+1). Code 7 behaves exactly like code 6 (bit 6, divide by 128).
- R6: Loading a new select code never disturbs tmr_count. This holds even when the load falls on the edge where the count wraps from 255 to 0.
- R7: With a fixed code, tmr_tick is high for exactly half of every 256-cycle span. It changes level only when the count bits below the tap are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter advances on each rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Processor word address |
| bus_wdata | input | 16 | Processor write data; bits [2:0] carry the select code |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| tmr_count | output | 8 | Current counter value |
| tmr_tick | output | 1 | Divided clock taken from the selected counter bit |

## Verification
Two events can land on the same edge: a select-code load, and the counter's wrap from 255 to 0. The bench provokes this by issuing the write in the cycle where its reference count shows 255. It then checks that tmr_count reads 0 on the next cycle and that tmr_tick already follows the new tap. A second pairing puts a write to the wrong address in a wrap cycle, and the bench confirms that the old tap stays in force.

// File: rtl/tmr_pkg.sv
// Package: shared sizing and tap mapping for the selectable-tap timer.
// Assumes the select code is narrow enough that 2**SEL_W stays small.
package tmr_pkg;
    localparam int CNT_W     = 8;
    localparam int SEL_W     = 3;
    localparam int ADDR_W    = 12;
    localparam int DATA_W    = 16;
    localparam logic [ADDR_W-1:0] TMR_ADDR = 12'h080;
    // Highest usable tap: divide by 2**(CNT_W-1).
    localparam int MAX_TAP   = CNT_W - 2;
    localparam int NUM_CODES = 1 << SEL_W;

    // Map a select code to a counter bit index, saturating at MAX_TAP.
    function automatic int tap_of(input int code);
        return (code > MAX_TAP) ? MAX_TAP : code;
    endfunction
endpackage

// File: rtl/tmr_counter.sv
// Module: tmr_counter
// Free-running up-counter with no enable and no prescaler; wraps naturally.
// Assumes: synchronous active-low reset, one increment per clock.
module tmr_counter #(
    parameter int W = tmr_pkg::CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] cnt_q
);
    // Advance by one every cycle; modulo wrap is implicit in the width.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/tmr_sel_reg.sv
// Module: tmr_sel_reg
// Address decode plus the select-code register.
// Assumes: single-cycle writes, strobe sampled on the rising edge.
module tmr_sel_reg #(
    parameter int                  AW   = tmr_pkg::ADDR_W,
    parameter int                  DW   = tmr_pkg::DATA_W,
    parameter int                  SW   = tmr_pkg::SEL_W,
    parameter logic [AW-1:0]       BASE = tmr_pkg::TMR_ADDR
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          wr,
    output logic [SW-1:0] sel_q
);
    logic hit;
    logic unused_hi;

    // Decode a write aimed at this peripheral.
    always_comb hit = wr && (addr == BASE);

    // Upper data bits are not stored.
    always_comb unused_hi = ^wdata[DW-1:SW];

    // Hold the select code; load the low data bits on a decoded write.
    always_ff @(posedge clk) begin
        if (!rst_n)   sel_q <= '0;
        else if (hit) sel_q <= wdata[SW-1:0];
    end
endmodule

// File: rtl/tmr_tap_mux.sv
// Module: tmr_tap_mux
// Routes one counter bit to the output according to the select code.
// Codes beyond the top tap saturate onto the top tap. Purely combinational.
module tmr_tap_mux #(
    parameter int CW = tmr_pkg::CNT_W,
    parameter int SW = tmr_pkg::SEL_W
) (
    input  logic [CW-1:0] cnt,
    input  logic [SW-1:0] sel,
    output logic          tap
);
    localparam int NC = 1 << SW;
    logic [NC-1:0] cand;

    // One candidate bit per code, with saturation fixed at elaboration.
    for (genvar i = 0; i < NC; i++) begin : g_cand
        localparam int T = tmr_pkg::tap_of(i);
        assign cand[i] = cnt[T];
    end

    // Pick the candidate for the current code.
    always_comb tap = cand[sel];
endmodule

// File: rtl/tmr_tap_timer.sv
// Module: tmr_tap_timer (top)
// Free-running 8-bit timer with a bus-written tap select and a divided output.
// Assumes: synchronous active-low reset; bus writes last one cycle.
module tmr_tap_timer (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [11:0] bus_addr,
    input  logic [15:0] bus_wdata,
    input  logic        bus_wr,
    output logic [7:0]  tmr_count,
    output logic        tmr_tick
);
    import tmr_pkg::*;

    logic [SEL_W-1:0] sel_q;

    tmr_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt_q (tmr_count)
    );

    tmr_sel_reg #(
        .AW(ADDR_W), .DW(DATA_W), .SW(SEL_W), .BASE(TMR_ADDR)
    ) u_sel (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .wr    (bus_wr),
        .sel_q (sel_q)
    );

    tmr_tap_mux #(.CW(CNT_W), .SW(SEL_W)) u_mux (
        .cnt (tmr_count),
        .sel (sel_q),
        .tap (tmr_tick)
    );
endmodule

// File: rtl/tmr_tap_timer_chk.sv
// Module: tmr_tap_timer_chk
// Property checker bound into tmr_tap_timer. Observes ports and the select register.
module tmr_tap_timer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [11:0] bus_addr,
    input logic [2:0] wr_code,
    input logic       bus_wr,
    input logic [7:0] tmr_count,
    input logic       tmr_tick,
    input logic [2:0] sel_q
);
    logic past_ok;
    logic [7:0] low_mask;

    // Mark that at least one cycle has been seen since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // Bits below the current tap; code 7 uses tap 6.
    always_comb low_mask = (8'd1 << ((sel_q == 3'd7) ? 3'd6 : sel_q)) - 8'd1;

    // R1: the cycle after a reset edge shows a cleared count, code and output.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (tmr_count == 8'd0 && sel_q == 3'd0 && tmr_tick == 1'b0));

    // R2, R6: the count steps by one every cycle, whatever the bus does.
    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> tmr_count == 8'($past(tmr_count) + 8'd1));

    // R3: a decoded write lands its code one cycle later.
    assert_sel_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(bus_wr && bus_addr == 12'h080)) |-> sel_q == $past(wr_code));

    // R4: without a decoded write the code holds.
    assert_sel_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(bus_wr && bus_addr == 12'h080)) |-> $stable(sel_q));

    // R7: with a fixed code, the output toggles only at a boundary of the lower bits.
    assert_tick_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $stable(sel_q) && tmr_tick != $past(tmr_tick))
            |-> (tmr_count & low_mask) == 8'd0);
endmodule

bind tmr_tap_timer tmr_tap_timer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .wr_code   (bus_wdata[2:0]),
    .bus_wr    (bus_wr),
    .tmr_count (tmr_count),
    .tmr_tick  (tmr_tick),
    .sel_q     (sel_q)
);

// File: tb/tb_tmr_tap_timer.sv
// Scoreboard bench: a driver pushes the expected count and tick, a monitor compares them.
module tb_tmr_tap_timer;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  tmr_count;
    logic        tmr_tick;

    int total = 0;
    int bad = 0;
    bit done = 0;

    typedef struct {
        logic [7:0] cnt;
        logic       tick;
        string      tag;
    } exp_t;
    exp_t sb[$];

    // Reference model state.
    logic [7:0] m_cnt = '0;
    logic [2:0] m_sel = '0;

    tmr_tap_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .tmr_count(tmr_count), .tmr_tick(tmr_tick)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Model built from the requirements: reset, increment, decoded load.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt <= 8'd0;
            m_sel <= 3'd0;
        end else begin
            m_cnt <= m_cnt + 8'd1;
            if (bus_wr && bus_addr == 12'h080) m_sel <= bus_wdata[2:0];
        end
    end

    function automatic logic model_tick(input logic [7:0] c, input logic [2:0] s);
        int k;
        k = (s > 3'd6) ? 6 : int'(s);
        return c[k];
    endfunction

    // Driver step: wait for a falling edge, push the expectation, drive the next inputs.
    task automatic step(input string tag, input logic wr, input logic [11:0] a,
                        input logic [15:0] d);
        exp_t e;
        @(negedge clk);
        e.cnt = m_cnt;
        e.tick = model_tick(m_cnt, m_sel);
        e.tag = tag;
        sb.push_back(e);
        bus_wr = wr;
        bus_addr = a;
        bus_wdata = d;
    endtask

    task automatic idle(input string tag, input int n);
        for (int i = 0; i < n; i++) step(tag, 1'b0, 12'h000, 16'h0000);
    endtask

    // Run idle cycles until the model count shows v.
    task automatic run_to(input string tag, input logic [7:0] v);
        while (m_cnt != v) idle(tag, 1);
    endtask

    task automatic report(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: pop and compare just after each falling edge.
    always @(negedge clk) begin
        #1;
        while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            total++;
            if (tmr_count !== e.cnt || tmr_tick !== e.tick) begin
                bad++;
                $display("FAIL %s actual=cnt %0d tick %0b expected=cnt %0d tick %0b",
                         e.tag, tmr_count, tmr_tick, e.cnt, e.tick);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int hi;
        // R1: held in reset, then the first cycle out of reset.
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        report("R1 count in reset", int'(tmr_count), 0);
        report("R1 tick in reset", int'(tmr_tick), 0);
        rst_n = 1'b1;
        idle("R1 first cycles", 2);

        // R2: free run across a full wrap at the default code.
        idle("R2 free run and wrap", 300);

        // R3, R5: every code, each long enough to cover its period.
        for (int c = 0; c < 8; c++) begin
            step("R3 load code", 1'b1, 12'h080, 16'(c));
            idle((c == 7) ? "R5 code 7 same as 6" : "R5 tap follows code", 260);
        end

        // R4: writes that miss the address, and a strobe-less cycle at the right address.
        step("R3 load code 2", 1'b1, 12'h080, 16'h0002);
        step("R4 wrong address", 1'b1, 12'h081, 16'h0005);
        step("R4 wrong address high", 1'b1, 12'h880, 16'h0006);
        step("R4 strobe low", 1'b0, 12'h080, 16'h0004);
        idle("R4 code unchanged", 20);

        // R3: upper data bits are dropped.
        step("R3 upper bits", 1'b1, 12'h080, 16'hFFF9);
        idle("R3 upper bits ignored", 70);

        // R6: load coinciding with the wrap edge.
        run_to("R6 approach wrap", 8'd255);
        step("R6 load at wrap", 1'b1, 12'h080, 16'h0004);
        idle("R6 count intact after wrap load", 40);
        run_to("R4 approach wrap", 8'd255);
        step("R4 miss at wrap", 1'b1, 12'h040, 16'h0000);
        idle("R4 code kept after wrap", 40);

        // R6: loads mid-count, back to back.
        step("R6 load mid", 1'b1, 12'h080, 16'h0001);
        step("R6 load mid", 1'b1, 12'h080, 16'h0006);
        step("R6 load mid", 1'b1, 12'h080, 16'h0000);
        idle("R6 count intact", 10);

        // R7: duty check over one full counter cycle at code 3.
        step("R7 load code 3", 1'b1, 12'h080, 16'h0003);
        idle("R7 settle", 1);
        hi = 0;
        for (int i = 0; i < 256; i++) begin
            idle("R7 duty window", 1);
            #1;
            if (tmr_tick) hi++;
        end
        report("R7 high cycles in 256", hi, 128);

        // R1: a second reset mid-run clears count and code.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        idle("R1 reset mid-run", 5);

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule